// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page table entries so that a virtual address can be turned into a physical address without a trip to memory. The virtual page number is split into a set index (its low bits) and a tag (the rest). The ways of the chosen set are searched in the same cycle. On a permitted hit the physical address is the stored physical page number joined with the page offset, which is never altered.

A lookup that finds no valid line with a matching tag reports a miss. An external table walker then fetches the entry and writes it back through the fill port. Each line carries four permission bits alongside the page number. An access that hits but is not allowed by those bits reports a protection fault, and no address is returned.

Lookups use a valid/ready pair that passes straight through: the lookup is combinational, so the response is valid in the cycle the request is offered. The request is accepted only while the consumer holds `rsp_ready` high, so `req_ready` follows `rsp_ready`. A fill is accepted whenever `fill_ready` is high, which is every cycle except one in which `flush` is asserted. Address widths, set count and way count are parameters, with at least two sets.

Top module: `xlat_tlb`

## Requirements
- R1: On a translated hit, `rsp_pa[PAGE_W-1:0]` equals `req_va[PAGE_W-1:0]`.
- R2: The set is `req_va[PAGE_W+IDX_W-1:PAGE_W]` and the tag is `req_va[VA_W-1:PAGE_W+IDX_W]`. The same tag under a different set index does not hit.
- R3: A read at a valid line with a matching tag gives `rsp_hit=1` and `rsp_pa = {ppn, offset}`.
- R4: With no valid matching line, `rsp_miss=1` and `rsp_pa=0`.
- R5: Permission bits are `fill_perm[3]` for user access allowed, `[2]` for read, `[1]` for write and `[0]` for execute. A hit gives `rsp_fault=1` and `rsp_pa=0` in any of these cases: `req_user` is set and bit 3 is clear; `req_write` is set and bit 1 is clear; `req_fetch` is set and bit 0 is clear; or the access is a plain read and bit 2 is clear.
- R6: `rsp_valid` equals `req_valid`, and `req_ready` equals `rsp_ready`. When valid, exactly one of hit, miss or fault is set. When idle, all three are zero.
- R7: A fill whose tag is absent from its set goes to the lowest-numbered invalid way.
- R8: When the set is full, a fill evicts the way named by that set's round-robin pointer. The pointer then advances by one and wraps after the last way.
- R9: A fill whose tag is already valid in its set overwrites that line. It evicts nothing and leaves the pointer unchanged.
- R10: A lookup in the same cycle as a fill sees the contents from before the fill. The next cycle sees the new entry.
- R11: `flush` clears every valid bit and every pointer in one cycle. A fill offered in that cycle is refused (`fill_ready=0`) and not written.
- R12: After reset all lines are invalid and every pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_va | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_hit | output | 1 | Permitted translation |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Entry found but access forbidden |
| rsp_pa | output | PA_W | Physical address on hit, else zero |
| fill_valid | input | 1 | Fill write offered |
| fill_ready | output | 1 | Fill accepted |
| fill_vpn | input | VA_W-PAGE_W | Virtual page number of the fill |
| fill_ppn | input | PA_W-PAGE_W | Physical page number to store |
| fill_perm | input | 4 | Permission bits of the fill |

## Verification
Two operations can land in the same cycle. A lookup can coincide with a fill of the very page it asks for, and a fill can coincide with a flush. The bench provokes the first by raising `fill_valid` and `req_valid` for the same page together. The scoreboard then expects a miss in that cycle and a hit in the next. It provokes the second by pulsing `flush` while a fill is offered, and it judges the result by `fill_ready` being low and by later lookups of that page missing. Replacement order is judged at the ports, by which earlier pages still hit after the set has overflowed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W  = 4;
  localparam int P_USER  = 3;
  localparam int P_READ  = 2;
  localparam int P_WRITE = 1;
  localparam int P_EXEC  = 0;

  // True when the stored permissions forbid the requested access
  function automatic logic access_denied(input logic [PERM_W-1:0] perm,
                                         input logic write,
                                         input logic fetch,
                                         input logic user);
    logic bad;
    bad = 1'b0;
    if (user && !perm[P_USER])              bad = 1'b1;
    if (write && !perm[P_WRITE])            bad = 1'b1;
    if (fetch && !perm[P_EXEC])             bad = 1'b1;
    if (!write && !fetch && !perm[P_READ])  bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  parameter int PPN_W = 18,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [WAYS-1:0]   lk_valid,
  output logic [TAG_W-1:0]  lk_tag  [WAYS],
  output logic [PPN_W-1:0]  lk_ppn  [WAYS],
  output logic [PERM_W-1:0] lk_perm [WAYS],
  input  logic [IDX_W-1:0]  fl_idx,
  output logic [WAYS-1:0]   fl_valid,
  output logic [TAG_W-1:0]  fl_tag  [WAYS]
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [PPN_W-1:0]  ppn_q  [SETS];
    logic [PERM_W-1:0] perm_q [SETS];
    logic              sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= '0;
      else if (flush) vld_q <= '0;
      else if (sel)   vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_idx]  <= wr_tag;
        ppn_q[wr_idx]  <= wr_ppn;
        perm_q[wr_idx] <= wr_perm;
      end
    end

    assign lk_valid[w] = vld_q[lk_idx];
    assign lk_tag[w]   = tag_q[lk_idx];
    assign lk_ppn[w]   = ppn_q[lk_idx];
    assign lk_perm[w]  = perm_q[lk_idx];
    assign fl_valid[w] = vld_q[fl_idx];
    assign fl_tag[w]   = tag_q[fl_idx];
  end
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  parameter int PPN_W = 18
) (
  input  logic [WAYS-1:0]   lk_valid,
  input  logic [TAG_W-1:0]  lk_tag  [WAYS],
  input  logic [PPN_W-1:0]  lk_ppn  [WAYS],
  input  logic [PERM_W-1:0] lk_perm [WAYS],
  input  logic [TAG_W-1:0]  req_tag,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm
);
  // Fills never duplicate a tag within a set, so an OR mux suffices
  always_comb begin
    hit  = 1'b0;
    ppn  = '0;
    perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_valid[w] && (lk_tag[w] == req_tag)) begin
        hit  = 1'b1;
        ppn  = ppn | lk_ppn[w];
        perm = perm | lk_perm[w];
      end
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [WAYS-1:0]  fl_valid,
  input  logic [TAG_W-1:0] fl_tag [WAYS],
  output logic [WAY_W-1:0] way
);
  localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic             same_found, inv_found, use_ptr;
  logic [WAY_W-1:0] same_way, inv_way;

  always_comb begin
    same_found = 1'b0;
    inv_found  = 1'b0;
    same_way   = '0;
    inv_way    = '0;
    // Walk downward so the lowest-numbered way wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fl_valid[w] && (fl_tag[w] == fill_tag)) begin
        same_found = 1'b1;
        same_way   = WAY_W'(w);
      end
      if (!fl_valid[w]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
    use_ptr = !same_found && !inv_found;
    if (same_found)     way = same_way;
    else if (inv_found) way = inv_way;
    else                way = ptr_q[fill_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (fill_en && use_ptr) begin
      ptr_q[fill_idx] <= (ptr_q[fill_idx] == LAST) ? '0 : ptr_q[fill_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 30,
  parameter int PAGE_W = 12,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_pa,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm
);
  logic [IDX_W-1:0]  lk_idx, fl_idx;
  logic [TAG_W-1:0]  req_tag, fl_tag_in;
  logic [WAYS-1:0]   lk_valid, fl_valid;
  logic [TAG_W-1:0]  lk_tag  [WAYS];
  logic [PPN_W-1:0]  lk_ppn  [WAYS];
  logic [PERM_W-1:0] lk_perm [WAYS];
  logic [TAG_W-1:0]  fl_tag  [WAYS];
  logic              fill_en, m_hit, denied;
  logic [PPN_W-1:0]  m_ppn;
  logic [PERM_W-1:0] m_perm;
  logic [WAY_W-1:0]  vict_way;

  assign lk_idx    = req_va[PAGE_W +: IDX_W];
  assign req_tag   = req_va[VA_W-1 -: TAG_W];
  assign fl_idx    = fill_vpn[IDX_W-1:0];
  assign fl_tag_in = fill_vpn[VPN_W-1 -: TAG_W];

  assign fill_ready = !flush;
  assign fill_en    = fill_valid && fill_ready;

  tlb_entry_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(fill_en), .wr_idx(fl_idx), .wr_way(vict_way),
    .wr_tag(fl_tag_in), .wr_ppn(fill_ppn), .wr_perm(fill_perm),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag),
    .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .fl_idx(fl_idx), .fl_valid(fl_valid), .fl_tag(fl_tag)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_match (
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .req_tag(req_tag), .hit(m_hit), .ppn(m_ppn), .perm(m_perm)
  );

  tlb_victim_sel #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
    .fill_idx(fl_idx), .fill_tag(fl_tag_in),
    .fl_valid(fl_valid), .fl_tag(fl_tag), .way(vict_way)
  );

  assign denied    = access_denied(m_perm, req_write, req_fetch, req_user);
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
  assign rsp_hit   = req_valid && m_hit && !denied;
  assign rsp_fault = req_valid && m_hit && denied;
  assign rsp_miss  = req_valid && !m_hit;
  assign rsp_pa    = rsp_hit ? {m_ppn, req_va[PAGE_W-1:0]} : '0;
endmodule

// File: rtl/xlat_tlb_checker.sv
module xlat_tlb_checker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 30,
  parameter int PAGE_W = 12,
  localparam int VPN_W = VA_W - PAGE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [VPN_W-1:0] fill_vpn
);
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  p_offset_thru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pa[PAGE_W-1:0] == req_va[PAGE_W-1:0]);

  p_miss_pa_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault) |-> rsp_pa == '0);

  p_fill_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(rsp_hit || rsp_fault));

  p_fill_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && fill_ready) && req_valid &&
     req_va[VA_W-1:PAGE_W] == $past(fill_vpn)) |-> !rsp_miss);
endmodule

bind xlat_tlb xlat_tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_va(req_va),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_pa(rsp_pa), .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_va = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_ready;
  logic [29:0] rsp_pa;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic [3:0]  fill_perm = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        h, m, f;
    logic [29:0] pa;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm)
  );

  function automatic logic [31:0] mkva(input logic [17:0] tag, input logic [1:0] idx,
                                       input logic [11:0] off);
    return {tag, idx, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per accepted response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R6: unexpected response hmf=%b%b%b expected none",
                   rsp_hit, rsp_miss, rsp_fault);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_hit !== e.h || rsp_miss !== e.m || rsp_fault !== e.f || rsp_pa !== e.pa) begin
            failures++;
            $display("FAIL %s: hmf=%b%b%b pa=%h expected hmf=%b%b%b pa=%h",
                     e.req, rsp_hit, rsp_miss, rsp_fault, rsp_pa, e.h, e.m, e.f, e.pa);
          end
        end
      end
    end
  end

  // kind: 0 hit, 1 miss, 2 fault
  task automatic look(input logic [17:0] tag, input logic [1:0] idx, input logic [11:0] off,
                      input logic w, input logic fx, input logic u,
                      input int kind, input logic [17:0] ppn, input string req);
    exp_t e;
    @(posedge clk); #1;
    req_va = mkva(tag, idx, off);
    req_write = w; req_fetch = fx; req_user = u; req_valid = 1'b1;
    e.h = (kind == 0); e.m = (kind == 1); e.f = (kind == 2);
    e.pa = (kind == 0) ? {ppn, off} : 30'd0;
    e.req = req;
    sb.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [17:0] tag, input logic [1:0] idx,
                      input logic [17:0] ppn, input logic [3:0] perm);
    @(posedge clk); #1;
    fill_vpn = {tag, idx}; fill_ppn = ppn; fill_perm = perm; fill_valid = 1'b1;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state visible at the ports
    chk("R12 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    chk("R11 fill_ready idle", {31'd0, fill_ready}, 32'd1);
    rst_n = 1'b1;
    look(18'h5, 2'd1, 12'h345, 0, 0, 0, 1, 0, "R12 empty after reset");
    // R3/R1: supervisor rwx page
    fill(18'h5, 2'd1, 18'h2A, 4'b0111);
    look(18'h5, 2'd1, 12'h345, 0, 0, 0, 0, 18'h2A, "R3 read hit");
    look(18'h5, 2'd1, 12'hFFF, 1, 0, 0, 0, 18'h2A, "R1 offset all ones");
    look(18'h5, 2'd1, 12'h000, 0, 1, 0, 0, 18'h2A, "R1 offset zero fetch");
    // R2: other set, other tag
    look(18'h5, 2'd2, 12'h345, 0, 0, 0, 1, 0, "R2 other set misses");
    look(18'h4, 2'd1, 12'h345, 0, 0, 0, 1, 0, "R4 other tag misses");
    // R5: permissions
    look(18'h5, 2'd1, 12'h010, 0, 0, 1, 2, 0, "R5 user on supervisor page");
    fill(18'h6, 2'd1, 18'h31, 4'b1100);
    look(18'h6, 2'd1, 12'h020, 1, 0, 1, 2, 0, "R5 write to read-only");
    look(18'h6, 2'd1, 12'h020, 0, 1, 1, 2, 0, "R5 fetch without exec");
    look(18'h6, 2'd1, 12'h020, 0, 0, 1, 0, 18'h31, "R5 user read allowed");
    fill(18'h7, 2'd1, 18'h32, 4'b1001);
    look(18'h7, 2'd1, 12'h030, 0, 0, 1, 2, 0, "R5 read without read bit");
    look(18'h7, 2'd1, 12'h030, 0, 1, 1, 0, 18'h32, "R5 fetch allowed");
    // R7/R8: fill way 3, then overflow the set twice
    fill(18'h8, 2'd1, 18'h33, 4'b1111);
    look(18'h5, 2'd1, 12'h001, 0, 0, 0, 0, 18'h2A, "R7 four pages coexist");
    look(18'h8, 2'd1, 12'h001, 0, 0, 0, 0, 18'h33, "R7 last invalid way used");
    fill(18'h9, 2'd1, 18'h34, 4'b1111);
    look(18'h5, 2'd1, 12'h002, 0, 0, 0, 1, 0, "R8 way0 evicted first");
    look(18'h9, 2'd1, 12'h002, 0, 0, 0, 0, 18'h34, "R8 new page present");
    look(18'h6, 2'd1, 12'h002, 0, 0, 1, 0, 18'h31, "R8 way1 kept");
    fill(18'hA, 2'd1, 18'h35, 4'b1111);
    look(18'h6, 2'd1, 12'h003, 0, 0, 1, 1, 0, "R8 way1 evicted second");
    look(18'h7, 2'd1, 12'h003, 0, 1, 0, 0, 18'h32, "R8 way2 kept");
    // R9: refill page in way3 while pointer names way2
    fill(18'h8, 2'd1, 18'h77, 4'b1111);
    look(18'h8, 2'd1, 12'h004, 0, 0, 0, 0, 18'h77, "R9 refill updates ppn");
    look(18'h7, 2'd1, 12'h004, 0, 1, 0, 0, 18'h32, "R9 refill evicts nothing");
    // R6: back-pressure passes through
    @(posedge clk); #1;
    rsp_ready = 1'b0; req_valid = 1'b1; req_va = mkva(18'h7, 2'd1, 12'h0);
    #1;
    chk("R6 req_ready follows rsp_ready", {31'd0, req_ready}, 32'd0);
    chk("R6 rsp_valid follows req_valid", {31'd0, rsp_valid}, 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    #1;
    chk("R6 idle outcome flags", {29'd0, rsp_hit, rsp_miss, rsp_fault}, 32'd0);
    rsp_ready = 1'b1;
    // R10: fill and lookup of the same page in one cycle
    begin
      exp_t e;
      @(posedge clk); #1;
      fill_vpn = {18'h11, 2'd3}; fill_ppn = 18'h55; fill_perm = 4'b0111; fill_valid = 1'b1;
      req_va = mkva(18'h11, 2'd3, 12'h0AB); req_write = 0; req_fetch = 0; req_user = 0;
      req_valid = 1'b1;
      e.h = 0; e.m = 1; e.f = 0; e.pa = 0; e.req = "R10 same-cycle sees old";
      sb.push_back(e);
      @(posedge clk); #1;
      fill_valid = 1'b0; req_valid = 1'b0;
    end
    look(18'h11, 2'd3, 12'h0AB, 0, 0, 0, 0, 18'h55, "R10 next cycle sees fill");
    // R11: flush with a competing fill
    @(posedge clk); #1;
    flush = 1'b1; fill_vpn = {18'h12, 2'd0}; fill_ppn = 18'h66; fill_perm = 4'b1111;
    fill_valid = 1'b1;
    #1;
    chk("R11 fill refused during flush", {31'd0, fill_ready}, 32'd0);
    @(posedge clk); #1;
    flush = 1'b0; fill_valid = 1'b0;
    look(18'h12, 2'd0, 12'h0, 0, 0, 0, 1, 0, "R11 flushed-cycle fill dropped");
    look(18'h9, 2'd1, 12'h0, 0, 0, 0, 1, 0, "R11 set1 cleared");
    look(18'h11, 2'd3, 12'h0, 0, 0, 0, 1, 0, "R11 set3 cleared");
    // R11: pointer reset, shown by replacement order
    for (int i = 0; i < 5; i++) fill(18'h20 + 18'(i), 2'd1, 18'h100 + 18'(i), 4'b1111);
    look(18'h20, 2'd1, 12'h0, 0, 0, 0, 1, 0, "R11 pointer restarted at way0");
    look(18'h22, 2'd1, 12'h0, 0, 0, 0, 0, 18'h102, "R11 way2 kept");
    look(18'h24, 2'd1, 12'h0, 0, 0, 0, 0, 18'h104, "R8 overflow page present");
    repeat (3) @(posedge clk);
    chk("R6 scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule